// File: doc/BRIEF.md
# Shared-Register Transmit Line Scanner

This block schedules transmission for a small serial multiplexer in which several asynchronous lines share a single transmit data register. Software picks the participating lines with a per-line enable mask. A scanner steps through the lines one per clock, in ascending order, and wraps from the last line back to line 0. It stops on the first enabled line whose character slot is free, sets a ready flag and shows that line's number in the control/status register. Software answers with one write to the transmit data register. That character goes to the reported line, the flag drops and the scan moves on.

Each line can hold only one pending character. Its serializer is modelled as a timer that stays busy for a set number of cycles after it is loaded, and the scanner does not offer a busy line. A transmit interrupt is raised while the ready flag and the interrupt enable are both set. A self-clearing clear bit resets the block's internal state over a fixed number of cycles.

Top module: `txscan_mux`

## Requirements
- R1: After reset, the control/status register (address 0) and the enable mask (address 1) read as zero, `irq` is low, and no line is busy.
- R2: Only lines whose mask bit is set (bit n for line n) are offered. They are offered in ascending order, one line examined per clock, wrapping from line NUM_LINES-1 to line 0, starting from line 0 after reset or clear.
- R3: Control/status layout: bit 0 is clear, bit 1 is scan enable, bit 2 is transmit interrupt enable, bit 15 is the read-only ready flag, and bits 8 and up (read-only) hold the number of the line being offered.
- R4: A write to the transmit data register (address 2, character in bits 7:0) while ready is set loads that character into the reported line. The same clock edge clears ready and the line becomes busy.
- R5: A write to the transmit data register while ready is clear loads no line and leaves every line's character unchanged.
- R6: A loaded line stays busy for BUSY_CYCLES cycles and is not offered until it is free again.
- R7: `irq` is high exactly when ready and the transmit interrupt enable are both set.
- R8: No line is offered while scan enable is clear. Clearing scan enable while ready is set drops ready one cycle later.
- R9: Writing 1 to the clear bit resets the mask, the control bits, the scanner and the lines. The clear bit reads 1 for CLR_CYCLES cycles after the write, then reads 0.
- R10: If the enable bit of the line being offered is cleared, the scanner drops ready, leaves that line and goes on to the next enabled line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control/status, 1 enable mask, 2 transmit data |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr` (combinational) |
| irq | output | 1 | Transmit interrupt request |
| ln_char | output | NUM_LINES*8 | Character last loaded into each line, line n in bits 8n+7:8n |
| ln_busy | output | NUM_LINES | Per-line serializer busy |

## Verification
The hardest case to reach is removing a line's enable bit while the scanner is stopped on it. The mask write has to land while ready is set and before any data write. The bench waits for ready on a two-line mask, rewrites the mask without that line, and then expects the other line to be offered with nothing loaded. Exclusion of busy lines is reached by enabling a single line and serving it once. The scanner then keeps circling past that line, and the bench checks on every cycle of the busy window that ready stays low.

// File: rtl/txscan_pkg.sv
package txscan_pkg;

    localparam int REG_W        = 16;
    localparam int CHAR_W       = 8;
    localparam int CSR_CLR_BIT  = 0;
    localparam int CSR_SCAN_BIT = 1;
    localparam int CSR_TIE_BIT  = 2;
    localparam int CSR_LINE_LSB = 8;
    localparam int CSR_RDY_BIT  = 15;

    typedef enum logic [1:0] {
        ADDR_CSR  = 2'd0,
        ADDR_MASK = 2'd1,
        ADDR_TDR  = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic scan_en;
        logic tx_ie;
    } ctrl_t;

    function automatic int line_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/txscan_scanner.sv
module txscan_scanner
    import txscan_pkg::*;
#(
    parameter int NUM_LINES = 4,
    localparam int LW = line_w(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scan_en,
    input  logic [NUM_LINES-1:0] enable_mask,
    input  logic [NUM_LINES-1:0] line_busy,
    input  logic                 tdr_wr,
    output logic                 ready,
    output logic [LW-1:0]        cur_line,
    output logic [NUM_LINES-1:0] load_vec
);

    logic [LW-1:0] nxt_line;
    logic          eligible;

    assign nxt_line = (cur_line == LW'(NUM_LINES - 1)) ? '0 : cur_line + 1'b1;
    assign eligible = enable_mask[cur_line] && !line_busy[cur_line];

    always_ff @(posedge clk) begin
        if (rst) begin
            ready    <= 1'b0;
            cur_line <= '0;
        end else if (!scan_en) begin
            ready <= 1'b0;
        end else if (ready) begin
            // leave the line when served or when its enable is withdrawn
            if (tdr_wr || !enable_mask[cur_line]) begin
                ready    <= 1'b0;
                cur_line <= nxt_line;
            end
        end else if (eligible) begin
            ready <= 1'b1;
        end else begin
            cur_line <= nxt_line;
        end
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_load
        assign load_vec[i] = ready && tdr_wr && (cur_line == LW'(i));
    end

endmodule

// File: rtl/txscan_lines.sv
module txscan_lines
    import txscan_pkg::*;
#(
    parameter int NUM_LINES   = 4,
    parameter int BUSY_CYCLES = 8,
    localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_LINES-1:0]        load_vec,
    input  logic [CHAR_W-1:0]           load_char,
    output logic [NUM_LINES*CHAR_W-1:0] line_char,
    output logic [NUM_LINES-1:0]        line_busy
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic [CW-1:0]     busy_cnt;
        logic [CHAR_W-1:0] hold_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                busy_cnt <= '0;
                hold_q   <= '0;
            end else if (load_vec[i]) begin
                busy_cnt <= CW'(BUSY_CYCLES);
                hold_q   <= load_char;
            end else if (busy_cnt != '0) begin
                busy_cnt <= busy_cnt - 1'b1;
            end
        end

        assign line_busy[i]                  = (busy_cnt != '0);
        assign line_char[i*CHAR_W +: CHAR_W] = hold_q;
    end

endmodule

// File: rtl/txscan_mux.sv
module txscan_mux
    import txscan_pkg::*;
#(
    parameter int NUM_LINES   = 4,
    parameter int BUSY_CYCLES = 8,
    parameter int CLR_CYCLES  = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [1:0]                  addr,
    input  logic [REG_W-1:0]            wr_data,
    output logic [REG_W-1:0]            rd_data,
    output logic                        irq,
    output logic [NUM_LINES*CHAR_W-1:0] ln_char,
    output logic [NUM_LINES-1:0]        ln_busy
);

    localparam int LW  = line_w(NUM_LINES);
    localparam int CCW = $clog2(CLR_CYCLES + 1);

    logic [CCW-1:0]       clr_cnt;
    logic                 clearing;
    logic                 int_rst;
    ctrl_t                ctrl_q;
    logic [NUM_LINES-1:0] mask_q;
    logic                 scan_rdy;
    logic [LW-1:0]        scan_line;
    logic [NUM_LINES-1:0] load_vec;
    logic                 csr_wr;
    logic                 mask_wr;
    logic                 tdr_wr;

    assign clearing = (clr_cnt != '0);
    assign int_rst  = rst || clearing;
    assign csr_wr   = wr_en && !clearing && (reg_addr_e'(addr) == ADDR_CSR);
    assign mask_wr  = wr_en && !clearing && (reg_addr_e'(addr) == ADDR_MASK);
    assign tdr_wr   = wr_en && !clearing && (reg_addr_e'(addr) == ADDR_TDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_cnt <= '0;
        end else if (csr_wr && wr_data[CSR_CLR_BIT]) begin
            clr_cnt <= CCW'(CLR_CYCLES);
        end else if (clearing) begin
            clr_cnt <= clr_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (int_rst) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else begin
            if (csr_wr && !wr_data[CSR_CLR_BIT]) begin
                ctrl_q.scan_en <= wr_data[CSR_SCAN_BIT];
                ctrl_q.tx_ie   <= wr_data[CSR_TIE_BIT];
            end
            if (mask_wr) begin
                mask_q <= wr_data[NUM_LINES-1:0];
            end
        end
    end

    txscan_scanner #(.NUM_LINES(NUM_LINES)) u_scan (
        .clk         (clk),
        .rst         (int_rst),
        .scan_en     (ctrl_q.scan_en),
        .enable_mask (mask_q),
        .line_busy   (ln_busy),
        .tdr_wr      (tdr_wr),
        .ready       (scan_rdy),
        .cur_line    (scan_line),
        .load_vec    (load_vec)
    );

    txscan_lines #(.NUM_LINES(NUM_LINES), .BUSY_CYCLES(BUSY_CYCLES)) u_lines (
        .clk       (clk),
        .rst       (int_rst),
        .load_vec  (load_vec),
        .load_char (wr_data[CHAR_W-1:0]),
        .line_char (ln_char),
        .line_busy (ln_busy)
    );

    always_comb begin
        rd_data = '0;
        unique case (reg_addr_e'(addr))
            ADDR_CSR: begin
                rd_data[CSR_CLR_BIT]               = clearing;
                rd_data[CSR_SCAN_BIT]              = ctrl_q.scan_en;
                rd_data[CSR_TIE_BIT]               = ctrl_q.tx_ie;
                rd_data[CSR_RDY_BIT]               = scan_rdy;
                rd_data[CSR_LINE_LSB +: LW]        = scan_line;
            end
            ADDR_MASK: rd_data[NUM_LINES-1:0] = mask_q;
            default:   rd_data = '0;
        endcase
    end

    assign irq = scan_rdy && ctrl_q.tx_ie;

endmodule

// File: rtl/txscan_checker.sv
module txscan_checker
    import txscan_pkg::*;
#(
    parameter int NUM_LINES = 4,
    localparam int LW = line_w(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 clearing,
    input logic                 scan_en,
    input logic [NUM_LINES-1:0] mask,
    input logic [LW-1:0]        cur_line,
    input logic                 rdy,
    input logic [NUM_LINES-1:0] busy,
    input logic [NUM_LINES-1:0] load_vec
);

    // R2: a newly raised ready flag points at a line that was enabled
    p_offer_enabled_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy) |-> $past(mask[cur_line]));

    // R6: the offered line is never busy
    p_offer_free_r6: assert property (@(posedge clk) disable iff (rst)
        rdy |-> !busy[cur_line]);

    // R4: at most one line loaded, and the load ends the offer and occupies a line
    p_single_load_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load_vec));
    p_load_effect_r4: assert property (@(posedge clk) disable iff (rst)
        (|load_vec) |=> (!rdy && (|busy)));

    // R8: scanning stops without scan enable
    p_scan_off_r8: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> !rdy);

    // R9: the clear sequence holds the mask and scanner reset
    p_clear_hold_r9: assert property (@(posedge clk) disable iff (rst)
        clearing |=> (mask == '0 && !rdy && busy == '0));

    // R10: withdrawn enable releases the halted scanner
    p_leave_line_r10: assert property (@(posedge clk) disable iff (rst)
        (rdy && !mask[cur_line] && !clearing) |=> !rdy);

endmodule

bind txscan_mux txscan_checker #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clearing (clearing),
    .scan_en  (ctrl_q.scan_en),
    .mask     (mask_q),
    .cur_line (scan_line),
    .rdy      (scan_rdy),
    .busy     (ln_busy),
    .load_vec (load_vec)
);

// File: tb/tb_txscan_mux.sv
module tb_txscan_mux;

    localparam int N     = 4;
    localparam int BUSY  = 8;
    localparam int CLR   = 4;
    localparam int RDY   = 15;
    localparam int LSB   = 8;

    // {mask, first..fourth served line}
    localparam logic [11:0] VEC [5] = '{
        {4'b1111, 2'd0, 2'd1, 2'd2, 2'd3},
        {4'b0101, 2'd0, 2'd2, 2'd0, 2'd2},
        {4'b1000, 2'd3, 2'd3, 2'd3, 2'd3},
        {4'b0110, 2'd1, 2'd2, 2'd1, 2'd2},
        {4'b1010, 2'd1, 2'd3, 2'd1, 2'd3}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [15:0]   wr_data = '0;
    logic [15:0]   rd_data;
    logic          irq;
    logic [N*8-1:0] ln_char;
    logic [N-1:0]  ln_busy;

    int total = 0;
    int fails = 0;
    logic [15:0] last_csr;

    always #10 clk = ~clk;

    txscan_mux #(.NUM_LINES(N), .BUSY_CYCLES(BUSY), .CLR_CYCLES(CLR)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq), .ln_char(ln_char), .ln_busy(ln_busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // write, then leave with the control/status register visible after the edge
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd0;
        #1 last_csr = rd_data;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic wait_ready(input string req, output logic [1:0] line);
        logic [15:0] v;
        bit got = 0;
        line = '0;
        for (int k = 0; k < 200; k++) begin
            rd(2'd0, v);
            if (v[RDY]) begin
                got = 1;
                line = v[LSB +: 2];
                break;
            end
        end
        check({req, " ready reached"}, 32'(got), 32'd1);
    endtask

    task automatic do_clear();
        logic [15:0] v;
        wr(2'd0, 16'h0001);
        for (int k = 0; k < 50; k++) begin
            rd(2'd0, v);
            if (!v[0]) break;
        end
    endtask

    initial begin
        #(20 * 100000);
        total++; fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [15:0] v;
        logic [1:0]  ln;
        int ones;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(2'd0, v); check("R1 csr", v, 16'h0000);
        rd(2'd1, v); check("R1 mask", v, 16'h0000);
        check("R1 irq", irq, 1'b0);
        check("R1 busy", ln_busy, '0);

        // R5 and R8: scan off, data write ignored, nothing offered
        wr(2'd1, 16'h000F);
        wr(2'd2, 16'h0055);
        check("R5 no line busy", ln_busy, '0);
        check("R5 chars unchanged", ln_char, '0);
        repeat (10) @(negedge clk);
        rd(2'd0, v); check("R8 no ready while scan off", v[RDY], 1'b0);

        // R7 (enable off) and R8 (dropping scan enable)
        wr(2'd0, 16'h0002);
        wait_ready("R8", ln);
        check("R3 first line", ln, 2'd0);
        check("R7 irq low with enable clear", irq, 1'b0);
        wr(2'd0, 16'h0000);
        rd(2'd0, v); check("R8 ready dropped", v[RDY], 1'b0);

        // R9: clear timing and effect
        wr(2'd0, 16'h0001);
        ones = last_csr[0] ? 1 : 0;
        for (int k = 0; k < 20; k++) begin
            rd(2'd0, v);
            if (!v[0]) break;
            ones++;
        end
        check("R9 clear bit high cycles", ones, CLR);
        rd(2'd1, v); check("R9 mask cleared", v, 16'h0000);
        rd(2'd0, v); check("R9 csr cleared", v, 16'h0000);

        // R10: withdraw enable of the halted line
        wr(2'd1, 16'h0003);
        wr(2'd0, 16'h0006);
        wait_ready("R10", ln);
        check("R10 halted line", ln, 2'd0);
        wr(2'd1, 16'h0002);
        wait_ready("R10", ln);
        check("R10 moved to next enabled", ln, 2'd1);
        check("R10 nothing loaded", ln_busy, '0);

        // R6: busy line is not offered during its busy window
        do_clear();
        wr(2'd1, 16'h0001);
        wr(2'd0, 16'h0006);
        wait_ready("R6", ln);
        wr(2'd2, 16'h00A5);
        check("R6 ready low after load", last_csr[RDY], 1'b0);
        check("R6 busy after load", ln_busy[0], 1'b1);
        for (int k = 1; k < BUSY; k++) begin
            rd(2'd0, v);
            check("R6 not offered while busy", v[RDY], 1'b0);
            check("R6 still busy", ln_busy[0], 1'b1);
        end
        rd(2'd0, v); check("R6 free after window", ln_busy[0], 1'b0);
        wait_ready("R6", ln);
        check("R6 offered again", ln, 2'd0);

        // R2, R3, R4, R7: table of masks and expected service order
        for (int t = 0; t < 5; t++) begin
            do_clear();
            wr(2'd1, {12'd0, VEC[t][11:8]});
            wr(2'd0, 16'h0006);
            for (int s = 0; s < 4; s++) begin
                logic [1:0] exp_ln;
                logic [7:0] ch;
                exp_ln = VEC[t][7 - 2*s -: 2];
                ch = 8'(8'h30 + t * 4 + s);
                wait_ready("R2", ln);
                check("R2 service order", ln, exp_ln);
                check("R7 irq with ready and enable", irq, 1'b1);
                wr(2'd2, {8'h00, ch});
                check("R4 ready cleared", last_csr[RDY], 1'b0);
                check("R4 char delivered", ln_char[exp_ln*8 +: 8], ch);
                check("R4 line busy", ln_busy[exp_ln], 1'b1);
            end
        end

        summary();
    end

endmodule